// File: doc/BRIEF.md
# Byte-Lane SDRAM Access Port

This block lets a client with an 8-bit data path use a 64-bit single-data-rate SDRAM. The memory is treated as eight independent byte lanes sharing one command and address bus. A narrow access selects a lane purely through the eight data-mask lines. The selected lane's mask bit is driven low at the cycle where data moves, and every other lane stays masked. No external multiplexer is needed. Row and column commands still reach every device on the shared select, but only the chosen lane writes or drives read data.

A client raises `req_valid` with a lane, bank, row, column, direction and write byte while `busy` is low. The block then runs one closed-page access. It issues ACTIVATE, waits T_RCD clocks and issues READ or WRITE. A read then waits CAS_LAT clocks for the data. Finally it issues a single-bank PRECHARGE and waits T_RP clocks. The memory is assumed to be programmed for full-page wrapping bursts. The burst therefore keeps running after the column command until the precharge ends it. The mask stays high on every lane during that time, so the extra beats neither corrupt memory nor reach the client. Read data is returned on `rd_data` with a one-cycle `rd_valid` pulse.

The controller is a single state machine with eight states:
- ST_IDLE waits for a request (IDLE→ACT on `req_valid`).
- ST_ACT issues ACTIVATE (ACT→RCD).
- ST_RCD counts out the row-to-column delay (RCD→WR or RCD→RD when the timer reaches zero).
- ST_WR issues WRITE (WR→PRE).
- ST_RD issues READ (RD→CAS).
- ST_CAS waits for the read data (CAS→PRE when the timer reaches zero).
- ST_PRE issues PRECHARGE (PRE→RP).
- ST_RP counts out the precharge time (RP→IDLE when the timer reaches zero).

Top module: `lane_sdram_port`

## Requirements
- R1: After reset and whenever `busy` is low, the command pins show NOP (`sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n` = 0,1,1,1), `sd_dqm` is all ones, `sd_dq_oe` is 0 and `rd_valid` is 0.
- R2: Each access issues ACTIVATE (0,0,1,1) with the bank on `sd_ba` and the row on the low bits of `sd_addr`. T_RCD clocks later it issues READ (0,1,0,1) or WRITE (0,1,0,0) to the same bank, with the column on the low bits of `sd_addr` and address bit 10 low. Later it issues PRECHARGE (0,0,1,0) to that bank with address bit 10 low. NOP is driven between these commands, and a bank is never activated twice without a precharge.
- R3: In the WRITE cycle, `sd_dq_oe` is 1 and the write byte is driven on all eight lanes. Lane n is `sd_dq_out[8n+7:8n]`, and its mask bit `sd_dqm[n]` is the only one driven low. The addressed byte then reads back as the written value.
- R4: On a read, `sd_dqm[n]` for the selected lane n is low only in the cycle CAS_LAT-2 clocks after the READ cycle. At most one mask bit is ever low, and in each access exactly one cycle has a low mask bit.
- R5: A read captures lane n of `sd_dq_in` CAS_LAT clocks after the READ cycle. `rd_valid` pulses high for exactly one cycle, 7 cycles after the request is accepted with default timing, and `rd_data` carries the captured byte.
- R6: A write leaves the other seven lanes of the addressed word unchanged. It also leaves every other column unchanged, including the columns the still-running full-page burst passes over.
- R7: `busy` rises the cycle after a request is accepted. It stays high for T_RCD+T_RP+1 cycles on a write (5 by default) and T_RCD+CAS_LAT+T_RP+1 cycles on a read (8 by default).
- R8: A request presented while `busy` is high is ignored. No extra command is issued and no memory content changes.
- R9: A write access never pulses `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the SDRAM |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, taken when `busy` is low |
| req_write | input | 1 | 1 = write byte, 0 = read byte |
| req_lane | input | $clog2(LANES) | Byte lane of the 64-bit word |
| req_bank | input | BANK_W | Internal bank |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | LANE_W | Byte to write |
| busy | output | 1 | Access in progress, including precharge recovery |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | LANE_W | Byte read from the selected lane |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Row or column address |
| sd_dqm | output | LANES | Per-lane data mask, high = masked |
| sd_dq_out | output | LANES*LANE_W | Write data toward the memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | LANES*LANE_W | Read data from the memory |

## Verification
The main function is tried in three stages, against a memory model that honours the mask with its write and read latencies and keeps bursting over the whole page:
- A full read of every byte of a small memory preloaded with an arithmetic pattern. This separates correct lane selection and mask timing from a mask or capture that is one clock early or late, since those return the model's undriven filler byte instead.
- A single-lane write to every word, with the lane rotating from word to word, followed by a write to a second lane. A complete re-read then tells a lane-exact write apart from one that spills into neighbouring lanes or into the columns the continuing burst passes over.
- A request raised while the block is busy, which tells ignoring apart from queuing or corrupting.

Busy length, read latency and the protocol record are checked on every access.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_RCD,
        ST_WR,
        ST_RD,
        ST_CAS,
        ST_PRE,
        ST_RP
    } lsp_state_e;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE
    } lsp_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } lsp_pins_t;

endpackage

// File: rtl/lsp_cmd_enc.sv
module lsp_cmd_enc
    import lsp_pkg::*;
(
    input  lsp_cmd_e  cmd,
    output lsp_pins_t pins
);

    always_comb begin
        unique case (cmd)
            CMD_ACT: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
            CMD_RD:  pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            CMD_WR:  pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
            CMD_PRE: pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            default: pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end

endmodule

// File: rtl/lsp_lane_mask.sv
module lsp_lane_mask #(
    parameter int LANES = 8,
    localparam int LSEL_W = $clog2(LANES)
) (
    input  logic [LSEL_W-1:0] lane,
    input  logic              open_lane,
    output logic [LANES-1:0]  dqm
);

    for (genvar g = 0; g < LANES; g++) begin : g_bit
        assign dqm[g] = !(open_lane && (lane == LSEL_W'(g)));
    end

endmodule

// File: rtl/lsp_lane_datapath.sv
module lsp_lane_datapath #(
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int LSEL_W = $clog2(LANES),
    localparam int DQ_W   = LANES * LANE_W
) (
    input  logic [LSEL_W-1:0] lane,
    input  logic [LANE_W-1:0] wbyte,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic [LANE_W-1:0] rbyte
);

    for (genvar g = 0; g < LANES; g++) begin : g_rep
        assign dq_out[g*LANE_W +: LANE_W] = wbyte;
    end

    always_comb begin
        rbyte = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane == LSEL_W'(i)) begin
                rbyte = dq_in[i*LANE_W +: LANE_W];
            end
        end
    end

endmodule

// File: rtl/lsp_wait_timer.sv
module lsp_wait_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             zero
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - CNT_W'(1);
        end
    end

    assign zero = (count == '0);

endmodule

// File: rtl/lane_sdram_port.sv
module lane_sdram_port
    import lsp_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int LANE_W  = 8,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 13,
    parameter int COL_W   = 9,
    parameter int ADDR_W  = 13,
    parameter int T_RCD   = 2,
    parameter int T_RP    = 2,
    parameter int CAS_LAT = 3,
    localparam int LSEL_W = $clog2(LANES),
    localparam int DQ_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LSEL_W-1:0] req_lane,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LANE_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [LANE_W-1:0] rd_data,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [LANES-1:0]  sd_dqm,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);

    localparam int CNT_W = $clog2(T_RCD + T_RP + CAS_LAT + 1);
    localparam logic [CNT_W-1:0] RCD_LOAD = CNT_W'(T_RCD - 2);
    localparam logic [CNT_W-1:0] CAS_LOAD = CNT_W'(CAS_LAT - 1);
    localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 2);
    localparam logic [CNT_W-1:0] MASK_AT  = CNT_W'(2);

    lsp_state_e state, state_nx;

    logic              wr_q;
    logic [LSEL_W-1:0] lane_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [LANE_W-1:0] wdata_q;

    logic              t_load;
    logic [CNT_W-1:0]  t_load_val;
    logic [CNT_W-1:0]  t_count;
    logic              t_zero;

    lsp_cmd_e          cmd;
    lsp_pins_t         pins;
    logic              lane_open;
    logic [LANE_W-1:0] lane_byte;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_ACT;
            ST_ACT:  state_nx = ST_RCD;
            ST_RCD:  if (t_zero) state_nx = wr_q ? ST_WR : ST_RD;
            ST_WR:   state_nx = ST_PRE;
            ST_RD:   state_nx = ST_CAS;
            ST_CAS:  if (t_zero) state_nx = ST_PRE;
            ST_PRE:  state_nx = ST_RP;
            ST_RP:   if (t_zero) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // request capture, only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            lane_q  <= '0;
            bank_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            wr_q    <= req_write;
            lane_q  <= req_lane;
            bank_q  <= req_bank;
            row_q   <= req_row;
            col_q   <= req_col;
            wdata_q <= req_wdata;
        end
    end

    // outputs per state
    always_comb begin
        cmd        = CMD_NOP;
        sd_ba      = '0;
        sd_addr    = '0;
        lane_open  = 1'b0;
        sd_dq_oe   = 1'b0;
        t_load     = 1'b0;
        t_load_val = '0;
        unique case (state)
            ST_ACT: begin
                cmd                  = CMD_ACT;
                sd_ba                = bank_q;
                sd_addr[ROW_W-1:0]   = row_q;
                t_load               = 1'b1;
                t_load_val           = RCD_LOAD;
            end
            ST_WR: begin
                cmd                  = CMD_WR;
                sd_ba                = bank_q;
                sd_addr[COL_W-1:0]   = col_q;
                lane_open            = 1'b1;
                sd_dq_oe             = 1'b1;
            end
            ST_RD: begin
                cmd                  = CMD_RD;
                sd_ba                = bank_q;
                sd_addr[COL_W-1:0]   = col_q;
                lane_open            = (CAS_LAT == 2);
                t_load               = 1'b1;
                t_load_val           = CAS_LOAD;
            end
            ST_CAS: begin
                lane_open            = (CAS_LAT > 2) && (t_count == MASK_AT);
            end
            ST_PRE: begin
                cmd                  = CMD_PRE;
                sd_ba                = bank_q;
                t_load               = 1'b1;
                t_load_val           = RP_LOAD;
            end
            default: begin
            end
        endcase
    end

    assign busy = (state != ST_IDLE);

    // read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (state == ST_CAS) && t_zero;
            if (state == ST_CAS && t_zero) begin
                rd_data <= lane_byte;
            end
        end
    end

    lsp_wait_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_load_val),
        .count    (t_count),
        .zero     (t_zero)
    );

    lsp_cmd_enc i_cmd_enc (
        .cmd  (cmd),
        .pins (pins)
    );

    assign sd_cs_n  = pins.cs_n;
    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;

    lsp_lane_mask #(.LANES(LANES)) i_mask (
        .lane      (lane_q),
        .open_lane (lane_open),
        .dqm       (sd_dqm)
    );

    lsp_lane_datapath #(.LANES(LANES), .LANE_W(LANE_W)) i_dp (
        .lane   (lane_q),
        .wbyte  (wdata_q),
        .dq_in  (sd_dq_in),
        .dq_out (sd_dq_out),
        .rbyte  (lane_byte)
    );

endmodule

// File: rtl/lsp_port_checker.sv
module lsp_port_checker #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             rd_valid,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [LANES-1:0] sd_dqm,
    input logic             sd_dq_oe
);

    logic is_nop, is_act, is_wr, is_pre, is_rd;
    assign is_nop = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111;
    assign is_act = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011;
    assign is_rd  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0101;
    assign is_wr  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0100;
    assign is_pre = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (is_nop && (&sd_dqm) && !sd_dq_oe && !rd_valid));

    // R4
    one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sd_dqm));

    // R3
    oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (is_wr && $countones(~sd_dqm) == 1));

    // R2
    act_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |=> is_nop);

    // R2
    pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |=> is_nop);

    // R2
    rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> (is_nop && !rd_valid));

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> is_act);

    // R8
    single_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$rose(busy)) |-> !is_act);

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (is_pre && busy));

    // R5
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

bind lane_sdram_port lsp_port_checker #(.LANES(LANES)) i_port_chk (.*);

// File: tb/test_lane_sdram_port.sv
module test_lane_sdram_port;

    localparam int NB = 4;
    localparam int NR = 8;
    localparam int NC = 8;
    localparam int NL = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_lane = '0;
    logic [1:0]  req_bank = '0;
    logic [2:0]  req_row = '0;
    logic [2:0]  req_col = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, rd_valid;
    logic [7:0]  rd_data;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [7:0]  sd_dqm;
    logic [63:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [63:0] sd_dq_in;

    int tests = 0;
    int fails = 0;
    int n_acc = 0;

    always #5 clk = ~clk;

    lane_sdram_port #(.ROW_W(3), .COL_W(3)) i_lane_sdram_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_lane(req_lane), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    function automatic logic [7:0] init_b(int b, int r, int c, int l);
        return 8'(b * 67 + r * 29 + c * 11 + l * 53 + 5);
    endfunction
    function automatic logic [7:0] wv1(int b, int r, int c);
        return 8'(b * 13 + r * 7 + c * 3 + 165);
    endfunction
    function automatic logic [7:0] wv2(int b, int r, int c);
        return ~wv1(b, r, c) ^ 8'h3C;
    endfunction
    function automatic int lane1(int b, int r, int c);
        return (b + r + c) % NL;
    endfunction
    function automatic int lane2(int b, int r, int c);
        return (lane1(b, r, c) + 3) % NL;
    endfunction
    function automatic int widx(int b, int r, int c);
        return b * NR * NC + r * NC + c;
    endfunction

    // memory model: mask write latency 0, mask read latency 2, CAS latency 3,
    // full-page wrapping bursts ended by precharge
    logic [63:0] mem [0:NB*NR*NC-1];
    int  open_b [NB];
    int  orow   [NB];
    int  act_cy [NB];
    int  cyc = 0;
    int  proto_err = 0;
    int  n_act = 0;
    int  n_dqm = 0;
    int  bon = 0, bwr = 0, bbank = 0, bcol = 0;
    logic [63:0] rp1 = {8{8'hEE}}, rp2 = {8{8'hEE}}, dq_drv = {8{8'hEE}};
    logic [7:0]  dqm_q = 8'hFF;
    assign sd_dq_in = dq_drv;

    initial begin
        for (int b = 0; b < NB; b++) begin
            open_b[b] = 0; orow[b] = 0; act_cy[b] = 0;
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    for (int l = 0; l < NL; l++)
                        mem[widx(b, r, c)][l*8 +: 8] = init_b(b, r, c, l);
        end
    end

    always @(posedge clk) begin
        logic [63:0] push;
        logic [3:0]  pins;
        int          b;
        push = {8{8'hEE}};
        pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        b    = int'(sd_ba);
        cyc++;
        if (rst_n) begin
            case (pins)
                4'b0011: begin
                    if (open_b[b] != 0) proto_err++;
                    open_b[b] = 1; orow[b] = int'(sd_addr[2:0]); act_cy[b] = cyc; n_act++;
                end
                4'b0101, 4'b0100: begin
                    if (open_b[b] == 0 || cyc - act_cy[b] < 2 || sd_addr[10]) proto_err++;
                    bon = 1; bwr = (pins == 4'b0100) ? 1 : 0; bbank = b; bcol = int'(sd_addr[2:0]);
                    if (bwr != 0) begin
                        if (!sd_dq_oe) proto_err++;
                        for (int l = 0; l < NL; l++)
                            if (!sd_dqm[l]) mem[widx(b, orow[b], bcol)][l*8 +: 8] = sd_dq_out[l*8 +: 8];
                    end else begin
                        push = mem[widx(b, orow[b], bcol)];
                    end
                end
                4'b0010: begin
                    if (open_b[b] == 0 || sd_addr[10]) proto_err++;
                    open_b[b] = 0;
                    if (bon != 0 && bbank == b) bon = 0;
                end
                4'b0111: begin
                    if (bon != 0) begin
                        bcol = (bcol + 1) % NC;
                        if (bwr != 0) begin
                            for (int l = 0; l < NL; l++)
                                if (!sd_dqm[l]) mem[widx(bbank, orow[bbank], bcol)][l*8 +: 8] = sd_dq_out[l*8 +: 8];
                        end else begin
                            push = mem[widx(bbank, orow[bbank], bcol)];
                        end
                    end
                end
                default: proto_err++;
            endcase
            if (sd_dqm != 8'hFF) n_dqm++;
        end
        rp1   <= push;
        rp2   <= rp1;
        dqm_q <= sd_dqm;
        for (int l = 0; l < NL; l++)
            dq_drv[l*8 +: 8] <= dqm_q[l] ? 8'hEE : rp2[l*8 +: 8];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic access(input bit wr, input int lane, input int b, input int r, input int c,
                          input logic [7:0] wb, output logic [7:0] rb,
                          output int busy_n, output int rv_at, output int rv_n);
        int k;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_lane = 3'(lane);
        req_bank = 2'(b); req_row = 3'(r); req_col = 3'(c); req_wdata = wb;
        @(negedge clk);
        req_valid = 1'b0;
        n_acc++;
        busy_n = 0; rv_at = 0; rv_n = 0; rb = 8'h00; k = 1;
        while (busy && k < 60) begin
            busy_n++;
            if (rd_valid) begin rv_n++; rv_at = k; rb = rd_data; end
            @(negedge clk);
            k++;
        end
        if (rd_valid) rv_n++;
    endtask

    task automatic read_check(input int b, input int r, input int c, input int l,
                              input logic [7:0] exp, input string tag);
        logic [7:0] rb;
        int bn, ra, rn;
        access(1'b0, l, b, r, c, 8'h00, rb, bn, ra, rn);
        chk(rb == exp, tag, int'(rb), int'(exp));
        chk(bn == 8, "R7 read busy length", bn, 8);
        chk(ra == 7 && rn == 1, "R5 read latency/pulse", ra * 10 + rn, 71);
    endtask

    task automatic write_do(input int b, input int r, input int c, input int l, input logic [7:0] v);
        logic [7:0] rb;
        int bn, ra, rn;
        access(1'b1, l, b, r, c, v, rb, bn, ra, rn);
        chk(bn == 5, "R7 write busy length", bn, 5);
        chk(rn == 0, "R9 no rd_valid on write", rn, 0);
    endtask

    initial begin
        logic [7:0] e;
        logic [7:0] rb;
        int bn;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !rd_valid, "R1 busy/rd_valid after reset", int'({busy, rd_valid}), 0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 NOP after reset",
            int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        chk(sd_dqm == 8'hFF && !sd_dq_oe, "R1 mask/oe after reset", int'({sd_dq_oe, sd_dqm}), 255);

        // sweep 1: read every byte of the preloaded pattern
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    for (int l = 0; l < NL; l++)
                        read_check(b, r, c, l, init_b(b, r, c, l), "R5 initial read");

        // sweep 2: one lane per word, then a second lane
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    write_do(b, r, c, lane1(b, r, c), wv1(b, r, c));
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    write_do(b, r, c, lane2(b, r, c), wv2(b, r, c));

        // sweep 3: re-read everything
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    for (int l = 0; l < NL; l++) begin
                        if (l == lane1(b, r, c)) read_check(b, r, c, l, wv1(b, r, c), "R3 first written lane");
                        else if (l == lane2(b, r, c)) read_check(b, r, c, l, wv2(b, r, c), "R3 second written lane");
                        else read_check(b, r, c, l, init_b(b, r, c, l), "R6 untouched lane");
                    end

        // R8: request raised while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_lane = 3'd5;
        req_bank = 2'd0; req_row = 3'd0; req_col = 3'd0; req_wdata = 8'h77;
        @(negedge clk);
        n_acc++;
        req_lane = 3'd0; req_bank = 2'd3; req_row = 3'd7; req_col = 3'd7; req_wdata = 8'h5A;
        bn = 0;
        for (int k = 0; k < 60 && busy; k++) begin
            bn++;
            if (k == 2) req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(bn == 5, "R8 busy length with request held", bn, 5);
        read_check(0, 0, 0, 5, 8'h77, "R3 write before ignored request");
        e = init_b(3, 7, 7, 0);
        read_check(3, 7, 7, 0, e, "R8 ignored request left memory unchanged");

        // protocol record
        chk(proto_err == 0, "R2 command protocol violations", proto_err, 0);
        chk(n_act == n_acc, "R2 one ACTIVATE per access", n_act, n_acc);
        chk(n_dqm == n_acc, "R4 one unmasked cycle per access", n_dqm, n_acc);
        @(negedge clk);
        chk(!busy && sd_dqm == 8'hFF && !sd_dq_oe, "R1 idle after traffic", int'({busy, sd_dq_oe}), 0);
        rb = rd_data;
        chk(!rd_valid, "R5 rd_valid low when idle", int'(rd_valid), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule